// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flag Register

This block keeps the interrupt enables and the latched event flags of a PC-style real-time clock. Three event sources feed it with single-cycle pulses: a periodic tick, an alarm match and an end-of-update event. Each pulse latches its own flag whether or not that source is enabled. A summary bit and an active-low interrupt line are raised only when some latched flag is also enabled.

Software reaches the block through a small register port with two addresses. Address 0 holds the enable bits. Address 1 holds the flags and is read-to-clear. The enable field and the flag field use the same bit positions, so one mask serves both registers. Clearing every enable and then reading the flags leaves the device quiet.

A two-state machine holds the summary. The states are IRQ_QUIET and IRQ_PENDING. The transition RAISE goes from IRQ_QUIET to IRQ_PENDING when the next-cycle flags, masked by the next-cycle enables, are non-zero. The transition DROP goes from IRQ_PENDING back to IRQ_QUIET when that masked value becomes zero, either because a flag read cleared the flags or because the enables were cleared. Otherwise the state holds.

Top module: `rtc_irq_flags`

## Requirements
- R1: After reset all flags and all enable bits are zero, both registers read 0x00 and irq_n is high.
- R2: An event pulse sets its flag from the next cycle, even when the enable bit is clear. In the flag register (address 1) the periodic flag is bit 6, the alarm flag is bit 5 and the update flag is bit 4. Bits 3..0 always read zero.
- R3: A write to address 0 loads the enables from data bits 6 (periodic), 5 (alarm) and 4 (update). Reading address 0 returns those bits in the same positions, with every other bit zero.
- R4: Flag-register bit 7 (summary) is set and irq_n is low exactly when at least one flag is set whose enable bit is also set. This takes effect from the cycle after the pulse.
- R5: A flag that is latched while masked does not drive irq_n low. Enabling it later drives irq_n low from the cycle after the enable write.
- R6: A read of address 1 returns all flags and the summary, then clears them. From the next cycle irq_n is high and a second read returns 0x00.
- R7: An event pulse in the same cycle as a flag-register read leaves that flag set after the read.
- R8: Clearing the enables while an interrupt is pending raises irq_n from the next cycle. A following flag read leaves flags, summary and irq_n quiet.
- R9: Writes to address 1 and reads of address 0 leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_periodic | input | 1 | Periodic tick pulse |
| evt_alarm | input | 1 | Alarm match pulse |
| evt_update | input | 1 | End-of-update pulse |
| reg_sel | input | 1 | Register address: 0 enables, 1 flags |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; a read of address 1 clears the flags |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while reg_rd is high, zero otherwise |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The main function is tried with every combination of the three enable bits against every combination of the three event pulses. Each combination tells apart a flag that latches while masked from one that also raises the summary bit and irq_n, and each ends with a read that must return everything and then leave zero. Separate sequences check a masked flag whose enable is set afterwards, an event that coincides with the clearing read, enables cleared while an interrupt is pending, and the accesses that must not disturb the flags.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    // Source index inside the flag and enable vectors. Bit position in
    // a register is FIELD_LSB + index.
    localparam int SRC_UPDATE   = 0;
    localparam int SRC_ALARM    = 1;
    localparam int SRC_PERIODIC = 2;

    typedef enum logic [0:0] {
        IRQ_QUIET   = 1'b0,
        IRQ_PENDING = 1'b1
    } irq_state_e;

endpackage

// File: rtl/rtc_irq_flag_bank.sv
module rtc_irq_flag_bank #(
    parameter int NUM_SRC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt,
    input  logic               clr,
    output logic [NUM_SRC-1:0] flag_q,
    output logic [NUM_SRC-1:0] flag_nxt
);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SRC; gi++) begin : g_flag
            // A pulse always wins over the clear, so no event is lost.
            assign flag_nxt[gi] = (flag_q[gi] & ~clr) | evt[gi];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    flag_q[gi] <= 1'b0;
                end else begin
                    flag_q[gi] <= flag_nxt[gi];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/rtc_irq_ctrl_reg.sv
module rtc_irq_ctrl_reg #(
    parameter int DATA_W    = 8,
    parameter int NUM_SRC   = 3,
    parameter int FIELD_LSB = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [DATA_W-1:0]  wdata,
    output logic [NUM_SRC-1:0] en_q,
    output logic [NUM_SRC-1:0] en_nxt
);

    localparam int FIELD_MSB = FIELD_LSB + NUM_SRC - 1;
    localparam logic [DATA_W-1:0] FIELD_MASK =
        DATA_W'(((1 << NUM_SRC) - 1) << FIELD_LSB);

    logic unused_wbits;
    assign unused_wbits = ^(wdata & ~FIELD_MASK);

    assign en_nxt = we ? wdata[FIELD_MSB:FIELD_LSB] : en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= en_nxt;
        end
    end

endmodule

// File: rtl/rtc_irq_summary_fsm.sv
module rtc_irq_summary_fsm
    import rtc_irq_pkg::*;
#(
    parameter int NUM_SRC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] flag_nxt,
    input  logic [NUM_SRC-1:0] en_nxt,
    output logic               summary,
    output logic               irq_n
);

    irq_state_e state_q, state_d;
    logic       hit;

    assign hit = |(flag_nxt & en_nxt);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:   if (hit)  state_d = IRQ_PENDING; // RAISE
            IRQ_PENDING: if (!hit) state_d = IRQ_QUIET;   // DROP
            default:     state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        summary = 1'b0;
        irq_n   = 1'b1;
        unique case (state_q)
            IRQ_QUIET:   begin summary = 1'b0; irq_n = 1'b1; end
            IRQ_PENDING: begin summary = 1'b1; irq_n = 1'b0; end
            default:     begin summary = 1'b0; irq_n = 1'b1; end
        endcase
    end

endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
    import rtc_irq_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int FIELD_LSB = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_periodic,
    input  logic              evt_alarm,
    input  logic              evt_update,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_n
);

    localparam int  NUM_SRC   = 3;
    localparam int  FIELD_MSB = FIELD_LSB + NUM_SRC - 1;
    localparam int  SUM_BIT   = FIELD_MSB + 1;
    localparam logic CTRL_ADDR = 1'b0;
    localparam logic FLAG_ADDR = 1'b1;

    logic [NUM_SRC-1:0] evt_vec;
    logic [NUM_SRC-1:0] flag_q, flag_nxt;
    logic [NUM_SRC-1:0] en_q, en_nxt;
    logic               summary_q;
    logic               ctrl_we;
    logic               flag_clr;

    always_comb begin
        evt_vec               = '0;
        evt_vec[SRC_PERIODIC] = evt_periodic;
        evt_vec[SRC_ALARM]    = evt_alarm;
        evt_vec[SRC_UPDATE]   = evt_update;
    end

    assign ctrl_we  = reg_wr && (reg_sel == CTRL_ADDR);
    assign flag_clr = reg_rd && (reg_sel == FLAG_ADDR);

    rtc_irq_ctrl_reg #(
        .DATA_W    (DATA_W),
        .NUM_SRC   (NUM_SRC),
        .FIELD_LSB (FIELD_LSB)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (ctrl_we),
        .wdata  (reg_wdata),
        .en_q   (en_q),
        .en_nxt (en_nxt)
    );

    rtc_irq_flag_bank #(
        .NUM_SRC (NUM_SRC)
    ) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_vec),
        .clr      (flag_clr),
        .flag_q   (flag_q),
        .flag_nxt (flag_nxt)
    );

    rtc_irq_summary_fsm #(
        .NUM_SRC (NUM_SRC)
    ) u_sum (
        .clk      (clk),
        .rst_n    (rst_n),
        .flag_nxt (flag_nxt),
        .en_nxt   (en_nxt),
        .summary  (summary_q),
        .irq_n    (irq_n)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            unique case (reg_sel)
                CTRL_ADDR: reg_rdata[FIELD_MSB:FIELD_LSB] = en_q;
                FLAG_ADDR: begin
                    reg_rdata[FIELD_MSB:FIELD_LSB] = flag_q;
                    reg_rdata[SUM_BIT]             = summary_q;
                end
                default:   reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/rtc_irq_flags_chk.sv
module rtc_irq_flags_chk #(
    parameter int NUM_SRC = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               evt_periodic,
    input logic               evt_alarm,
    input logic               evt_update,
    input logic               reg_sel,
    input logic               reg_wr,
    input logic               reg_rd,
    input logic [NUM_SRC-1:0] flag_q,
    input logic [NUM_SRC-1:0] en_q,
    input logic               irq_n
);

    logic any_evt;
    logic flag_rd;
    assign any_evt = evt_periodic | evt_alarm | evt_update;
    assign flag_rd = reg_rd & reg_sel;

    AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        evt_periodic |=> flag_q[2]) else $error("periodic pulse lost"); // R2

    AST_UPDATE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        evt_update |=> flag_q[0]) else $error("update pulse lost"); // R2

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> ((flag_q & en_q) != '0)) else $error("irq without enabled flag"); // R4

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & en_q) == '0) && !any_evt && !reg_wr |=> irq_n)
        else $error("irq from masked flag"); // R5

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flag_rd && !any_evt |=> (flag_q == '0) && irq_n)
        else $error("read did not clear"); // R6

    AST_RACE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        flag_rd && evt_alarm |=> flag_q[1]) else $error("racing pulse lost"); // R7

    AST_NO_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_rd && !any_evt |=> $stable(flag_q)) else $error("flags changed"); // R9

endmodule

bind rtc_irq_flags rtc_irq_flags_chk #(.NUM_SRC(3)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_periodic (evt_periodic),
    .evt_alarm    (evt_alarm),
    .evt_update   (evt_update),
    .reg_sel      (reg_sel),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .flag_q       (flag_q),
    .en_q         (en_q),
    .irq_n        (irq_n)
);

// File: tb/rtc_irq_flags_test.sv
`timescale 1ns/1ps
module rtc_irq_flags_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_periodic = 1'b0, evt_alarm = 1'b0, evt_update = 1'b0;
    logic       reg_sel = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    rtc_irq_flags uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_periodic (evt_periodic),
        .evt_alarm    (evt_alarm),
        .evt_update   (evt_update),
        .reg_sel      (reg_sel),
        .reg_wr       (reg_wr),
        .reg_rd       (reg_rd),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .irq_n        (irq_n)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    // pattern bit 2 = periodic, 1 = alarm, 0 = update; field at bits 6..4
    task automatic pulse(input logic [2:0] p);
        @(negedge clk);
        {evt_periodic, evt_alarm, evt_update} = p;
        @(negedge clk);
        {evt_periodic, evt_alarm, evt_update} = 3'b000;
    endtask

    task automatic write_reg(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_sel = a; reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic read_reg(input logic a, output logic [7:0] v);
        @(negedge clk);
        reg_sel = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic logic [7:0] flag_word(input logic [2:0] fl, input logic [2:0] en);
        return {(|(fl & en)), fl, 4'b0000};
    endfunction

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        check("R1 irq_n at reset", {7'd0, irq_n}, 8'h01);
        rst_n = 1'b1;
        read_reg(1'b0, v); check("R1 ctrl after reset", v, 8'h00);
        read_reg(1'b1, v); check("R1 flags after reset", v, 8'h00);

        // full sweep: every enable mask against every event pattern
        for (int e = 0; e < 8; e++) begin
            write_reg(1'b0, {1'b1, 3'(e), 4'hF});
            read_reg(1'b0, v); check("R3 ctrl readback", v, {1'b0, 3'(e), 4'h0});
            for (int p = 0; p < 8; p++) begin
                pulse(3'(p));
                check("R4 irq_n after pulse", {7'd0, irq_n}, {7'd0, ~(|(3'(p) & 3'(e)))});
                read_reg(1'b1, v); check("R2 R4 flag word", v, flag_word(3'(p), 3'(e)));
                check("R6 irq_n after read", {7'd0, irq_n}, 8'h01);
                read_reg(1'b1, v); check("R6 second read", v, 8'h00);
            end
        end

        // masked flag, enabled afterwards
        write_reg(1'b0, 8'h00);
        pulse(3'b010);
        check("R5 masked alarm irq_n", {7'd0, irq_n}, 8'h01);
        write_reg(1'b0, 8'h20);
        check("R5 enable later irq_n", {7'd0, irq_n}, 8'h00);
        read_reg(1'b1, v); check("R5 flag word", v, 8'hA0);

        // event coinciding with the clearing read
        pulse(3'b100);
        @(negedge clk);
        reg_sel = 1'b1; reg_rd = 1'b1; evt_alarm = 1'b1;
        #1 v = reg_rdata;
        check("R7 read before race", v, 8'h40);
        @(negedge clk);
        reg_rd = 1'b0; evt_alarm = 1'b0;
        check("R7 irq_n after race", {7'd0, irq_n}, 8'h00);
        read_reg(1'b1, v); check("R7 alarm kept", v, 8'hA0);

        // clearing the enables while pending
        write_reg(1'b0, 8'h70);
        pulse(3'b111);
        check("R8 pending", {7'd0, irq_n}, 8'h00);
        write_reg(1'b0, 8'h00);
        check("R8 irq_n after disable", {7'd0, irq_n}, 8'h01);
        read_reg(1'b1, v); check("R8 flags masked", v, 8'h70);
        read_reg(1'b1, v); check("R8 quiet", v, 8'h00);
        check("R8 irq_n quiet", {7'd0, irq_n}, 8'h01);

        // accesses that must leave the flags alone
        pulse(3'b001);
        write_reg(1'b1, 8'hFF);
        read_reg(1'b0, v); check("R9 ctrl after flag write", v, 8'h00);
        read_reg(1'b1, v); check("R9 flags unchanged", v, 8'h10);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R1 got timeout exp completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule